// File: doc/BRIEF.md
# Bit-Serial GHASH Multiplier

This block computes the GF(2^128) products used to authenticate data in Galois/counter mode. It works on 128-bit element groups, each made of four 32-bit elements, and offers two operations. The hash step folds a data block X into the running tag Y and multiplies the sum by the subkey H. The multiply-only step multiplies Y by H and ignores X. Every operand is bit-reversed within each byte before use, and the product is bit-reversed within each byte on the way out. The multiply consumes one multiplier bit per clock. After each bit, H shifts left and is reduced by XORing 0x87 into its low byte when a bit falls off the top.

A caller pulses start with an operation select, a start element index and a vector length. The block then walks the element groups from the start index divided by four up to the vector length divided by four, minus one. For each group it requests operands and waits for an acknowledge, which is the load cycle. It then multiplies for 128 cycles and presents the result for write-back in place of Y. A one-cycle done pulse closes the run, and the caller uses it to clear its start element index to zero. Register storage and instruction decoding belong to the caller.

Top module: `ghash_serial_unit`

## Requirements
- R1: After reset, busy_o, req_valid_o, wr_valid_o and done_o are all 0.
- R2: For a run with start index vs and length vl, the groups requested and written back are vs/4 up to vl/4-1, in ascending order. Each group is requested once, and its index appears on req_grp_o and on wr_grp_o.
- R3: If vs/4 is greater than or equal to vl/4, no operand request is made, and done_o is 1 in the cycle right after the start cycle.
- R4: With op_i=0 (hash step), the result is brev8(Z), where Z is computed as follows. S = brev8(Y xor X) and H0 = brev8(H). Z starts at 0. For each bit b from 0 to 127 in ascending order, Z takes Z xor H when S[b] is 1. H then shifts left by one, and its low byte is XORed with 0x87 when its bit 127 was 1 before the shift. brev8 reverses the bit order inside each byte and keeps the bytes in place.
- R5: With op_i=1 (multiply only), the multiplier is brev8(Y) and x_i has no effect on the result.
- R6: Counting the clock edge that accepts req_ack_i as edge 1, wr_valid_o is 1 for exactly one cycle, starting after edge 129 (one load cycle followed by 128 bit steps).
- R7: done_o is 1 for exactly one cycle, the cycle after the write-back of the last group, and busy_o is 0 in the cycle after that.
- R8: A start pulse while busy_o is 1 is ignored. The run in progress keeps its operation and its group sequence, and no further run follows it.
- R9: result_o stays unchanged from the write-back cycle until the next acknowledged operand request, even if the operand inputs change.
- R10: While req_valid_o is 1 and req_ack_i is 0, the request stays up and req_grp_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin a run; taken only while idle |
| op_i | input | 1 | 0 = hash step, 1 = multiply only |
| vstart_i | input | IDX_W | Start element index |
| vl_i | input | IDX_W | Vector length in elements |
| busy_o | output | 1 | A run is in progress |
| req_valid_o | output | 1 | Operands requested for group req_grp_o |
| req_grp_o | output | IDX_W-2 | Group index of the request |
| req_ack_i | input | 1 | Operands are valid on y_i, x_i and h_i this cycle |
| y_i | input | 128 | Accumulator group |
| x_i | input | 128 | Data block group |
| h_i | input | 128 | Subkey group |
| wr_valid_o | output | 1 | result_o is to be written to group wr_grp_o |
| wr_grp_o | output | IDX_W-2 | Group index of the write-back |
| result_o | output | 128 | Product, bit-reversed within each byte |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
Within one bit step, the accumulate into Z and the reduction of H can both act. The accumulate must use the H from before the shift, while the reduction acts on the shifted value. All-ones operands make both happen on every step, and random operands make them coincide often. Each product is compared with an independent bench model of R4. A second coincidence is a new start arriving in the middle of a multiply. It is judged by checking that the group sequence, the operation and the done timing of the run in progress stay the same.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  typedef enum logic [0:0] {
    OP_HASH = 1'b0,
    OP_MUL  = 1'b1
  } ghash_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_MUL,
    ST_WB,
    ST_FIN
  } ghash_state_e;
endpackage

// File: rtl/ghash_bitserial_mul.sv
module ghash_bitserial_mul #(
  parameter int unsigned DATA_W   = 128,
  parameter logic [7:0]  RED_POLY = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              op_hash_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] h_i,
  output logic              last_o,
  output logic [DATA_W-1:0] prod_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam int unsigned NBYTE = DATA_W / 8;
  localparam logic [DATA_W-1:0] POLY_EXT = {{(DATA_W-8){1'b0}}, RED_POLY};

  logic [DATA_W-1:0] s_q, s_n, h_q, h_n, z_q, z_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] s_in, s_rev, h_rev;
  logic              en;

  assign s_in = op_hash_i ? (y_i ^ x_i) : y_i;

  // reverse bits inside every byte of the multiplier, subkey and product
  for (genvar gb = 0; gb < NBYTE; gb++) begin : g_byte
    for (genvar gi = 0; gi < 8; gi++) begin : g_bit
      assign s_rev[8*gb+gi]  = s_in[8*gb+7-gi];
      assign h_rev[8*gb+gi]  = h_i[8*gb+7-gi];
      assign prod_o[8*gb+gi] = z_q[8*gb+7-gi];
    end
  end

  assign en     = load_i | step_i;
  assign last_o = (cnt_q == CNT_W'(DATA_W-1));

  always_comb begin
    s_n   = s_q;
    h_n   = h_q;
    z_n   = z_q;
    cnt_n = cnt_q;
    if (load_i) begin
      s_n   = s_rev;
      h_n   = h_rev;
      z_n   = '0;
      cnt_n = '0;
    end else if (step_i) begin
      z_n   = s_q[0] ? (z_q ^ h_q) : z_q;
      h_n   = {h_q[DATA_W-2:0], 1'b0} ^ (h_q[DATA_W-1] ? POLY_EXT : '0);
      s_n   = s_q >> 1;
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= '0;
      h_q   <= '0;
      z_q   <= '0;
      cnt_q <= '0;
    end else if (en) begin
      s_q   <= s_n;
      h_q   <= h_n;
      z_q   <= z_n;
      cnt_q <= cnt_n;
    end
  end

  // R6: a load restarts the bit count
  p_load_clears_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0));
  // R9: product only moves while stepping or loading
  p_prod_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && !step_i |=> $stable(prod_o));
endmodule

// File: rtl/ghash_group_seq.sv
module ghash_group_seq
  import ghash_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned GRP_SH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    op_i,
  input  logic [IDX_W-1:0]        vstart_i,
  input  logic [IDX_W-1:0]        vl_i,
  input  logic                    req_ack_i,
  input  logic                    mul_last_i,
  output logic                    busy_o,
  output logic                    req_valid_o,
  output logic [IDX_W-GRP_SH-1:0] grp_o,
  output logic                    load_o,
  output logic                    step_o,
  output logic                    wr_valid_o,
  output logic                    done_o,
  output logic                    op_hash_o
);
  localparam int unsigned GRP_W = IDX_W - GRP_SH;

  ghash_state_e     state_q, state_n;
  logic [GRP_W-1:0] grp_q, grp_n, last_q, last_n;
  logic             op_q, op_n;
  logic [GRP_W-1:0] first_w, count_w;
  logic             empty_w;

  assign first_w = vstart_i[IDX_W-1:GRP_SH];
  assign count_w = vl_i[IDX_W-1:GRP_SH];
  assign empty_w = (first_w >= count_w);

  always_comb begin
    state_n = state_q;
    grp_n   = grp_q;
    last_n  = last_q;
    op_n    = op_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        op_n = op_i;
        if (empty_w) begin
          state_n = ST_FIN;
        end else begin
          grp_n   = first_w;
          last_n  = count_w - 1'b1;
          state_n = ST_REQ;
        end
      end
      ST_REQ:  if (req_ack_i) state_n = ST_MUL;
      ST_MUL:  if (mul_last_i) state_n = ST_WB;
      ST_WB: begin
        if (grp_q == last_q) begin
          state_n = ST_FIN;
        end else begin
          grp_n   = grp_q + 1'b1;
          state_n = ST_REQ;
        end
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grp_q   <= '0;
      last_q  <= '0;
      op_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      grp_q   <= grp_n;
      last_q  <= last_n;
      op_q    <= op_n;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign req_valid_o = (state_q == ST_REQ);
  assign load_o      = (state_q == ST_REQ) && req_ack_i;
  assign step_o      = (state_q == ST_MUL);
  assign wr_valid_o  = (state_q == ST_WB);
  assign done_o      = (state_q == ST_FIN);
  assign grp_o       = grp_q;
  assign op_hash_o   = (op_q == OP_HASH);

  // R10: pending request keeps its group
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ack_i |=> req_valid_o && $stable(grp_o));
  // R3: empty range finishes on the next cycle
  p_empty_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && empty_w |=> done_o);
  // R7: done is a single-cycle pulse followed by idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  // R8: a start while busy does not change the operation
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(op_hash_o));
  // R2: requested group never passes the last group
  p_grp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> grp_q <= last_q);
endmodule

// File: rtl/ghash_serial_unit.sv
module ghash_serial_unit #(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned ELEM_W   = 32,
  parameter int unsigned DATA_W   = 128,
  parameter logic [7:0]  RED_POLY = 8'h87
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    op_i,
  input  logic [IDX_W-1:0]        vstart_i,
  input  logic [IDX_W-1:0]        vl_i,
  output logic                    busy_o,
  output logic                    req_valid_o,
  output logic [IDX_W-2-1:0]      req_grp_o,
  input  logic                    req_ack_i,
  input  logic [DATA_W-1:0]       y_i,
  input  logic [DATA_W-1:0]       x_i,
  input  logic [DATA_W-1:0]       h_i,
  output logic                    wr_valid_o,
  output logic [IDX_W-2-1:0]      wr_grp_o,
  output logic [DATA_W-1:0]       result_o,
  output logic                    done_o
);
  localparam int unsigned GRP_SH = $clog2(DATA_W / ELEM_W);
  localparam int unsigned GRP_W  = IDX_W - GRP_SH;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             load_w, step_w, last_w, op_hash_w;
  logic [GRP_W-1:0] grp_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ghash_group_seq #(.IDX_W(IDX_W), .GRP_SH(GRP_SH)) seq_i (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .op_i(op_i),
    .vstart_i(vstart_i), .vl_i(vl_i), .req_ack_i(req_ack_i),
    .mul_last_i(last_w), .busy_o(busy_o), .req_valid_o(req_valid_o),
    .grp_o(grp_w), .load_o(load_w), .step_o(step_w),
    .wr_valid_o(wr_valid_o), .done_o(done_o), .op_hash_o(op_hash_w)
  );

  ghash_bitserial_mul #(.DATA_W(DATA_W), .RED_POLY(RED_POLY)) mul_i (
    .clk(clk), .rst_n(rst_int_n), .load_i(load_w), .step_i(step_w),
    .op_hash_i(op_hash_w), .y_i(y_i), .x_i(x_i), .h_i(h_i),
    .last_o(last_w), .prod_o(result_o)
  );

  assign req_grp_o = grp_w;
  assign wr_grp_o  = grp_w;

  // R6: write-back lasts one cycle
  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_valid_o |=> !wr_valid_o);
  // R9: result held after write-back
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_valid_o |=> $stable(result_o));
endmodule

// File: tb/ghash_serial_unit_tb.sv
module ghash_serial_unit_tb_top;
  logic         clk, rst_n, start_i, op_i, req_ack_i;
  logic [7:0]   vstart_i, vl_i;
  logic         busy_o, req_valid_o, wr_valid_o, done_o;
  logic [5:0]   req_grp_o, wr_grp_o;
  logic [127:0] y_i, x_i, h_i, result_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  ghash_serial_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .vstart_i(vstart_i), .vl_i(vl_i), .busy_o(busy_o),
    .req_valid_o(req_valid_o), .req_grp_o(req_grp_o), .req_ack_i(req_ack_i),
    .y_i(y_i), .x_i(x_i), .h_i(h_i), .wr_valid_o(wr_valid_o),
    .wr_grp_o(wr_grp_o), .result_o(result_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [127:0] rev_bytes(input logic [127:0] v);
    logic [127:0] r;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 8; j++) r[8*i+j] = v[8*i+7-j];
    return r;
  endfunction

  function automatic logic [127:0] ref_mul(input logic op, input logic [127:0] y,
                                           input logic [127:0] x, input logic [127:0] h);
    logic [127:0] s, hh, z;
    logic red;
    s  = rev_bytes(op ? y : (y ^ x));
    hh = rev_bytes(h);
    z  = '0;
    for (int b = 0; b < 128; b++) begin
      if (s[b]) z = z ^ hh;
      red = hh[127];
      hh  = hh << 1;
      if (red) hh[7:0] = hh[7:0] ^ 8'h87;
    end
    return rev_bytes(z);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pat: 0 random, 1 all zeros, 2 all ones, 3 ones subkey with random data
  task automatic run(input logic op, input int vs, input int vl, input int pat,
                     input int ack_dly, input bit poke);
    int first = vs / 4;
    int cnt   = vl / 4;
    int n;
    logic [127:0] exp, held;
    @(negedge clk);
    start_i = 1'b1; op_i = op; vstart_i = 8'(vs); vl_i = 8'(vl);
    @(negedge clk);
    start_i = 1'b0;
    if (first >= cnt) begin
      chk(done_o === 1'b1, "R3 done after start", 128'(done_o), 128'd1);
      chk(req_valid_o === 1'b0, "R3 no request", 128'(req_valid_o), 128'd0);
      @(negedge clk);
      chk(done_o === 1'b0 && busy_o === 1'b0, "R7 idle after done",
          128'({done_o, busy_o}), 128'd0);
      return;
    end
    for (int g = first; g < cnt; g++) begin
      n = 0;
      while (!req_valid_o && n < 50) begin @(negedge clk); n++; end
      chk(req_valid_o === 1'b1 && req_grp_o == 6'(g), "R2 request group",
          128'(req_grp_o), 128'(g));
      for (int d = 0; d < ack_dly; d++) begin
        @(negedge clk);
        chk(req_valid_o === 1'b1 && req_grp_o == 6'(g), "R10 request held",
            128'(req_grp_o), 128'(g));
      end
      case (pat)
        1:       begin y_i = '0; x_i = '0; h_i = '0; end
        2:       begin y_i = '1; x_i = '0; h_i = '1; end
        3:       begin y_i = rnd128(); x_i = rnd128(); h_i = '1; end
        default: begin y_i = rnd128(); x_i = rnd128(); h_i = rnd128(); end
      endcase
      exp = ref_mul(op, y_i, x_i, h_i);
      req_ack_i = 1'b1;
      @(negedge clk);
      req_ack_i = 1'b0;
      // R5: x has no effect in multiply-only mode; vary it after load
      if (op) x_i = ~x_i;
      n = 1;
      while (!wr_valid_o && n < 400) begin
        @(negedge clk);
        n++;
        if (poke && n == 20) begin start_i = 1'b1; op_i = ~op; vstart_i = 8'd0; vl_i = 8'd40; end
        if (poke && n == 21) start_i = 1'b0;
      end
      chk(n == 129, "R6 writeback latency", 128'(n), 128'd129);
      chk(wr_grp_o == 6'(g), "R2 writeback group", 128'(wr_grp_o), 128'(g));
      chk(result_o === exp, op ? "R5 multiply-only result" : "R4 hash-step result",
          result_o, exp);
      held = result_o;
      y_i = rnd128(); x_i = rnd128(); h_i = rnd128();
      @(negedge clk);
      chk(wr_valid_o === 1'b0, "R6 writeback single cycle", 128'(wr_valid_o), 128'd0);
      chk(result_o === held, "R9 result held", result_o, held);
      if (g == cnt - 1) begin
        chk(done_o === 1'b1, "R7 done after last writeback", 128'(done_o), 128'd1);
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0 && req_valid_o === 1'b0,
            "R8 R7 idle after run", 128'({done_o, busy_o, req_valid_o}), 128'd0);
      end else begin
        chk(done_o === 1'b0, "R7 no early done", 128'(done_o), 128'd0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start_i = 1'b0; op_i = 1'b0; req_ack_i = 1'b0;
    vstart_i = '0; vl_i = '0; y_i = '0; x_i = '0; h_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy_o, req_valid_o, wr_valid_o, done_o} === 4'b0, "R1 reset state",
        128'({busy_o, req_valid_o, wr_valid_o, done_o}), 128'd0);
    run(1'b0, 0, 8, 0, 0, 1'b0);
    run(1'b1, 4, 16, 0, 2, 1'b0);
    run(1'b0, 5, 11, 0, 1, 1'b1);
    run(1'b1, 0, 7, 0, 0, 1'b1);
    run(1'b0, 0, 4, 1, 0, 1'b0);
    run(1'b0, 0, 4, 2, 0, 1'b0);
    run(1'b1, 0, 4, 2, 3, 1'b0);
    run(1'b0, 8, 16, 3, 0, 1'b0);
    run(1'b1, 12, 16, 3, 1, 1'b0);
    run(1'b0, 8, 8, 0, 0, 1'b0);
    run(1'b1, 12, 4, 0, 0, 1'b0);
    run(1'b0, 0, 0, 0, 0, 1'b0);
    for (int k = 0; k < 6; k++) run(1'($urandom % 2), 0, 4, 0, k % 3, 1'b0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule